// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel TFT panel: horizontal sync, vertical sync, a data-enable strobe, the column and row of the current active pixel, and a pulse that marks the first visible pixel of each frame. It advances only on cycles where the pixel-clock enable is high, so it can run from a fast system clock.

Software sets the horizontal timing word, the vertical timing word and a control word over a small write-only register bus. Each timing field is stored as a packed value, and most fields are minus-one encoded. The control word holds a run bit and one polarity inversion per output. Timing words are staged. The counters pick them up only at the wrap from the last pixel of the last line, so a frame in progress is never torn. The run bit and the polarity bits take effect on the next clock.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset, hsyncOut, vsyncOut, deOut, pclkInvOut and frameStart are 0, and xPos and yPos are 0.
- R2: Horizontal word (address 0): bits 7:2 = width/16 − 1, bits 15:8 = sync − 1, bits 23:16 = front porch − 1, bits 31:24 = back porch − 1. Each line runs sync, back porch, active, front porch, in that order, with those lengths in enabled pixel cycles.
- R3: Vertical word (address 1): bits 9:0 = active lines − 1, bits 15:10 = sync lines − 1, bits 23:16 = front porch lines, bits 31:24 = back porch lines. Either porch may be zero lines. Each frame runs sync, back porch, active, front porch, counted in whole lines.
- R4: The data enable is active only where the horizontal and vertical positions are both inside their active regions.
- R5: While the data enable is active, xPos gives the pixel index within the line and yPos gives the line index within the active area. Both count from 0.
- R6: frameStart is high for exactly one clock: the enabled cycle of the first active pixel of active line 0. The data enable is active in that cycle.
- R7: Nothing advances in a cycle where pixEn is low. The outputs hold, and frameStart stays low.
- R8: A timing word written mid-frame takes effect only at the following frame boundary.
- R9: The control word (address 2) has a run bit at bit 0. While the run bit is 0, the counters are held at zero and hsync, vsync and the data enable sit at their inactive levels, whatever pixEn does.
- R10: Control bit 11 inverts vsync, bit 12 inverts hsync, bit 13 drives pclkInvOut, and bit 14 inverts the data enable. With an invert bit clear, the matching output is active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixEn | input | 1 | Pixel clock enable |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 horizontal, 1 vertical, 2 control |
| regWdata | input | 32 | Register write data |
| hsyncOut | output | 1 | Horizontal sync after polarity |
| vsyncOut | output | 1 | Vertical sync after polarity |
| deOut | output | 1 | Data enable after polarity |
| pclkInvOut | output | 1 | Pixel clock inversion select |
| frameStart | output | 1 | Pulse at the first active pixel of a frame |
| xPos | output | 12 | Active pixel column |
| yPos | output | 11 | Active line row |

## Verification
The in-line assertions watch these properties on every cycle:
- the counters hold on cycles without a pixel enable;
- both counters stay inside the frame defined by the loaded timing;
- frameStart never lasts two cycles and always falls inside the data enable;
- the syncs sit at their inactive levels while the run bit is clear.

The exact phase lengths, the field positions, the deferred adoption of a new timing word at the frame wrap, and the position outputs can only be shown by the bench. It replays full frames of several small timings, including zero-line porches, sparse pixel enables and inverted polarities, against an arithmetic model of the raster.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

  // Horizontal timing word; the bit positions follow the register layout.
  typedef struct packed {
    logic [7:0] hbp;   // back porch - 1
    logic [7:0] hfp;   // front porch - 1
    logic [7:0] hsw;   // sync width - 1
    logic [5:0] ppl;   // width / 16 - 1
    logic [1:0] rsvd;
  } hTiming_t;

  // Vertical timing word.
  typedef struct packed {
    logic [7:0] vbp;   // back porch lines
    logic [7:0] vfp;   // front porch lines
    logic [5:0] vsw;   // sync lines - 1
    logic [9:0] lpp;   // active lines - 1
  } vTiming_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic hSync;
    logic vSync;
    logic hAct;
    logic vAct;
    logic pixStep;
    logic lineEnd;
    logic frameEnd;
    logic frameStart;
  } ctlStrobes_t;

  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_INV_VS    = 11;
  localparam int CTRL_INV_HS    = 12;
  localparam int CTRL_INV_PCLK  = 13;
  localparam int CTRL_INV_DE    = 14;

endpackage

// File: rtl/lcd_raster_ctl.sv
module lcd_raster_ctl
  import lcd_raster_pkg::*;
#(
  parameter int H_CNT_W = 12,
  parameter int V_CNT_W = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixEn,
  input  logic        run,
  input  hTiming_t    hCfg,
  input  vTiming_t    vCfg,
  output ctlStrobes_t st
);

  logic [H_CNT_W-1:0] hCnt, hSyncLen, hActStart, hActEnd, hTotal;
  logic [V_CNT_W-1:0] vCnt, vSyncLen, vActStart, vActEnd, vTotal;
  logic lastPix, lastLine, step;

  // Phase boundaries derived from the loaded timing words.
  assign hSyncLen  = H_CNT_W'(hCfg.hsw) + H_CNT_W'(1);
  assign hActStart = hSyncLen + H_CNT_W'(hCfg.hbp) + H_CNT_W'(1);
  assign hActEnd   = hActStart + H_CNT_W'({hCfg.ppl, 4'b0000}) + H_CNT_W'(16);
  assign hTotal    = hActEnd + H_CNT_W'(hCfg.hfp) + H_CNT_W'(1);

  assign vSyncLen  = V_CNT_W'(vCfg.vsw) + V_CNT_W'(1);
  assign vActStart = vSyncLen + V_CNT_W'(vCfg.vbp);
  assign vActEnd   = vActStart + V_CNT_W'(vCfg.lpp) + V_CNT_W'(1);
  assign vTotal    = vActEnd + V_CNT_W'(vCfg.vfp);

  assign lastPix  = (hCnt == hTotal - H_CNT_W'(1));
  assign lastLine = (vCnt == vTotal - V_CNT_W'(1));
  assign step     = run & pixEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!run) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (pixEn) begin
      if (lastPix) begin
        hCnt <= '0;
        vCnt <= lastLine ? '0 : vCnt + V_CNT_W'(1);
      end else begin
        hCnt <= hCnt + H_CNT_W'(1);
      end
    end
  end

  always_comb begin
    st            = '0;
    st.hSync      = run & (hCnt < hSyncLen);
    st.vSync      = run & (vCnt < vSyncLen);
    st.hAct       = run & (hCnt >= hActStart) & (hCnt < hActEnd);
    st.vAct       = run & (vCnt >= vActStart) & (vCnt < vActEnd);
    st.pixStep    = step;
    st.lineEnd    = step & lastPix;
    st.frameEnd   = step & lastPix & lastLine;
    st.frameStart = step & (hCnt == hActStart) & (vCnt == vActStart);
  end

  AST_HOLD_NO_PIXEN: assert property (@(posedge clk) disable iff (!rstN)
    (run && !pixEn) |=> ($stable(hCnt) && $stable(vCnt))); // R7
  AST_H_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (hCnt < hTotal)); // R2
  AST_V_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (vCnt < vTotal)); // R3
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    st.frameStart |=> !st.frameStart); // R6

endmodule

// File: rtl/lcd_raster_dp.sv
module lcd_raster_dp
  import lcd_raster_pkg::*;
#(
  parameter int H_CNT_W = 12,
  parameter int V_CNT_W = 11,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  ctlStrobes_t        st,
  output hTiming_t           hCfg,
  output vTiming_t           vCfg,
  output logic               run,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic               pclkInvOut,
  output logic [H_CNT_W-1:0] xPos,
  output logic [V_CNT_W-1:0] yPos
);

  localparam int N_POL = 3;

  logic [DATA_W-1:0] progH, progV, ctrlWord;
  logic              loadShadow;
  logic [N_POL-1:0]  rawSig, invSig, polSig;

  // Staged timing words and the control word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progH    <= '0;
      progV    <= '0;
      ctrlWord <= '0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_W'(0): progH    <= regWdata;
        ADDR_W'(1): progV    <= regWdata;
        ADDR_W'(2): ctrlWord <= regWdata;
        default: ;
      endcase
    end
  end

  assign run        = ctrlWord[CTRL_RUN_BIT];
  assign loadShadow = !run | st.frameEnd;

  // Live timing is adopted only at the frame wrap or while stopped.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCfg <= '0;
      vCfg <= '0;
    end else if (loadShadow) begin
      hCfg <= hTiming_t'(progH);
      vCfg <= vTiming_t'(progV);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPos <= '0;
      yPos <= '0;
    end else begin
      if (!run || st.lineEnd)          xPos <= '0;
      else if (st.pixStep && st.hAct)  xPos <= xPos + H_CNT_W'(1);
      if (!run || st.frameEnd)         yPos <= '0;
      else if (st.lineEnd && st.vAct)  yPos <= yPos + V_CNT_W'(1);
    end
  end

  assign rawSig = {st.hAct & st.vAct, st.hSync, st.vSync};
  assign invSig = {ctrlWord[CTRL_INV_DE], ctrlWord[CTRL_INV_HS], ctrlWord[CTRL_INV_VS]};

  for (genvar i = 0; i < N_POL; i++) begin : g_pol
    assign polSig[i] = rawSig[i] ^ invSig[i];
  end

  assign deOut      = polSig[2];
  assign hsyncOut   = polSig[1];
  assign vsyncOut   = polSig[0];
  assign pclkInvOut = ctrlWord[CTRL_INV_PCLK];

  AST_IDLE_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (hsyncOut == invSig[1] && vsyncOut == invSig[0] && deOut == invSig[2])); // R9
  AST_FS_IN_DE: assert property (@(posedge clk) disable iff (!rstN)
    st.frameStart |-> (deOut != invSig[2])); // R6

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_raster_pkg::*;
#(
  parameter int H_CNT_W = 12,
  parameter int V_CNT_W = 11,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixEn,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic               pclkInvOut,
  output logic               frameStart,
  output logic [H_CNT_W-1:0] xPos,
  output logic [V_CNT_W-1:0] yPos
);

  ctlStrobes_t st;
  hTiming_t    hCfg;
  vTiming_t    vCfg;
  logic        run;

  lcd_raster_ctl #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .run(run),
    .hCfg(hCfg), .vCfg(vCfg), .st(st)
  );

  lcd_raster_dp #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W),
                  .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .st(st), .hCfg(hCfg), .vCfg(vCfg), .run(run),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pclkInvOut(pclkInvOut), .xPos(xPos), .yPos(yPos)
  );

  assign frameStart = st.frameStart;

endmodule

// File: tb/lcd_raster_timer_bench.sv
`timescale 1ns/1ps
module lcd_raster_timer_bench;

  logic        clk = 0;
  logic        rstN = 0;
  logic        pixEn = 0;
  logic        regWe = 0;
  logic [1:0]  regAddr = 0;
  logic [31:0] regWdata = 0;
  logic        hsyncOut, vsyncOut, deOut, pclkInvOut, frameStart;
  logic [11:0] xPos;
  logic [10:0] yPos;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] curH, curV, pendH, pendV, ctrlW;
  int bh, bv;

  always #4 clk = ~clk;

  lcd_raster_timer u_lcd_raster_timer (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .pclkInvOut(pclkInvOut), .frameStart(frameStart),
    .xPos(xPos), .yPos(yPos)
  );

  function automatic logic [31:0] mkH(int ppl, int hsw, int hbp, int hfp);
    return {hbp[7:0], hfp[7:0], hsw[7:0], ppl[5:0], 2'b00};
  endfunction
  function automatic logic [31:0] mkV(int lpp, int vsw, int vbp, int vfp);
    return {vbp[7:0], vfp[7:0], vsw[5:0], lpp[9:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    pixEn = 0; regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0;
    if (a == 0) begin pendH = d; end
    if (a == 1) begin pendV = d; end
    if (a == 2) begin
      ctrlW = d;
      curH = pendH; curV = pendV; bh = 0; bv = 0;
    end
  endtask

  task automatic startCfg(input logic [31:0] h, input logic [31:0] v, input logic [31:0] c);
    wr(2, 32'h0);
    wr(0, h);
    wr(1, v);
    wr(2, c | 32'h1);
  endtask

  // Replays cycles against an arithmetic model; optional mid-run write at writeAt.
  task automatic runCycles(input int n, input int enPeriod, input int writeAt,
                           input logic [1:0] wa, input logic [31:0] wd, input string lbl);
    int eH = 0, eV = 0, eD = 0, eP = 0, eF = 0, fsSeen = 0, fsExp = 0;
    for (int i = 0; i < n; i++) begin
      int hsw, hbp, hfp, w, vsw, vbp, vfp, nl, has, hae, hTot, vas, vae, vTot;
      bit hs, vs, ha, va, fs;
      @(negedge clk);
      pixEn = ((i % enPeriod) == 0);
      regWe = (i == writeAt); regAddr = wa; regWdata = wd;
      #1;
      hsw = int'(curH[15:8]) + 1; hfp = int'(curH[23:16]) + 1;
      hbp = int'(curH[31:24]) + 1; w = (int'(curH[7:2]) + 1) * 16;
      nl = int'(curV[9:0]) + 1; vsw = int'(curV[15:10]) + 1;
      vfp = int'(curV[23:16]); vbp = int'(curV[31:24]);
      has = hsw + hbp; hae = has + w; hTot = hae + hfp;
      vas = vsw + vbp; vae = vas + nl; vTot = vae + vfp;
      hs = bh < hsw; vs = bv < vsw;
      ha = (bh >= has) && (bh < hae); va = (bv >= vas) && (bv < vae);
      fs = pixEn && bh == has && bv == vas;
      if (hsyncOut !== (hs ^ ctrlW[12])) eH++;
      if (vsyncOut !== (vs ^ ctrlW[11])) eV++;
      if (deOut !== ((ha && va) ^ ctrlW[14])) eD++;
      if (ha && va && (int'(xPos) != bh - has || int'(yPos) != bv - vas)) eP++;
      if (frameStart !== fs) eF++;
      if (fs) fsExp++;
      if (frameStart === 1'b1) fsSeen++;
      if ((eH + eV + eD + eP + eF) == 1 && ((hsyncOut !== (hs ^ ctrlW[12])) ||
          (vsyncOut !== (vs ^ ctrlW[11])) || (deOut !== ((ha && va) ^ ctrlW[14]))))
        $display("mismatch %s at cycle %0d h=%0d v=%0d", lbl, i, bh, bv);
      if (i == writeAt) begin
        if (wa == 0) pendH = wd;
        if (wa == 1) pendV = wd;
      end
      if (pixEn) begin
        bh++;
        if (bh == hTot) begin
          bh = 0; bv++;
          if (bv == vTot) begin bv = 0; curH = pendH; curV = pendV; end
        end
      end
    end
    regWe = 0;
    chk(eH == 0, {"R2 hsync phases ", lbl}, eH, 0);
    chk(eV == 0, {"R3 vsync phases ", lbl}, eV, 0);
    chk(eD == 0, {"R4 data enable ", lbl}, eD, 0);
    chk(eP == 0, {"R5 positions ", lbl}, eP, 0);
    chk(eF == 0 && fsSeen == fsExp, {"R6 frame start ", lbl}, fsSeen, fsExp);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] h1, v1, h2, v2, h3, v3;
    bit ok;
    int eR9;
    h1 = mkH(0, 5, 5, 5);   v1 = mkV(3, 1, 2, 1);
    h2 = mkH(1, 7, 9, 6);   v2 = mkV(1, 0, 0, 0);
    h3 = mkH(0, 12, 5, 20); v3 = mkV(4, 3, 1, 3);
    pendH = 0; pendV = 0; curH = 0; curV = 0; ctrlW = 0; bh = 0; bv = 0;

    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    ok = !hsyncOut && !vsyncOut && !deOut && !pclkInvOut && !frameStart && xPos == 0 && yPos == 0;
    chk(ok, "R1 reset outputs", {hsyncOut, vsyncOut, deOut, pclkInvOut, frameStart}, 0);

    // R2 R3 basic sweeps, including zero-line porches
    startCfg(h1, v1, 32'h0);
    runCycles(2 * 306 + 20, 1, -1, 3, 0, "cfg1");
    startCfg(h2, v2, 32'h0);
    runCycles(2 * 171 + 20, 1, -1, 3, 0, "cfg2 zero porches");
    startCfg(h3, v3, 32'h0);
    runCycles(2 * 728 + 20, 1, -1, 3, 0, "cfg3");

    // R7 sparse pixel enable
    startCfg(h1, v1, 32'h0);
    runCycles(3 * 306 + 30, 3, -1, 3, 0, "R7 sparse enable");

    // R10 all polarity inversions
    startCfg(h2, v2, 32'h7800);
    chk(pclkInvOut === 1'b1, "R10 pixel clock invert", pclkInvOut, 1);
    runCycles(2 * 171 + 10, 1, -1, 3, 0, "R10 inverted");

    // R8 mid-frame timing write is deferred to the frame wrap
    startCfg(h1, v1, 32'h0);
    runCycles(306 + 504 + 60, 1, 40, 0, h3, "R8 deferred write");

    // R9 stop: counters held, syncs at inactive (inverted) levels
    wr(2, 32'h5800);
    eR9 = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      pixEn = 1;
      #1;
      if (hsyncOut !== 1'b1 || vsyncOut !== 1'b1 || deOut !== 1'b1 ||
          frameStart !== 1'b0 || xPos != 0 || yPos != 0) eR9++;
    end
    chk(eR9 == 0, "R9 stopped outputs inactive", eR9, 0);
    wr(2, 32'h0);
    @(negedge clk); #1;
    chk(!hsyncOut && !vsyncOut && !deOut && !pclkInvOut, "R9 R10 stopped, no inversion",
        {hsyncOut, vsyncOut, deOut, pclkInvOut}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule